// File: doc/BRIEF.md
# MDIO Management Register Bridge

This block lets a host reach the management registers of an Ethernet PHY through three indirect host registers, and it drives the two-wire serial management interface (a clock MDC and a bidirectional data line MDIO) to do so. The host puts a PHY address and a register address into a shared address/data word. For writes, the outgoing value goes into the same word. The host then writes the control register with a function index and a write-enable bit.

If the index names the access-initiate function, the bridge sends one complete 64-bit management frame. The host polls the ready register until its completion bit is set. After a read, the host takes the 16-bit value the PHY returned from the address/data word. MDC comes from a divider on the system clock, and the half period is set on an input. At a 100 MHz system clock a setting of 20 gives 2.5 MHz.

Host registers, selected by `host_addr`: 0 is the address/data word, 1 is control, 2 is ready, and 3 reads as zero. Host reads are combinational.

Top module: `mdio_bridge`

## Requirements
- R1: After reset the address/data word and control register read 0, the ready register reads 0x00010000, MDC is low and `mdio_oe` is low.
- R2: The PHY address is taken from address/data bits [9:5] and the register address from bits [4:0]. Each is sent MSB first, right after the opcode.
- R3: Writing control with bits [9:0] equal to `INIT_IDX` and bit 15 clear, while idle, sends a read frame with opcode 10.
- R4: The same control write with bit 15 set sends a write frame with opcode 01, turnaround 10 and the 16 data bits from address/data bits [31:16]. A write leaves the address/data word unchanged.
- R5: A control write whose bits [9:0] differ from `INIT_IDX` is stored but starts no frame.
- R6: Ready bit 16 reads 0 from the cycle after a start until the frame ends, and 1 otherwise. All other ready bits read 0.
- R7: In a read frame, `mdio_oe` is high for the first 46 bits and low from the turnaround to the end. The 16 bits on `mdio_i` at the MDC rising edges of bits 48..63 are placed MSB first into address/data bits [15:0], and bits [31:16] are kept.
- R8: MDC is low while idle. During a frame each MDC level lasts `mdc_half` system cycles, and a value of 0 acts as 1. MDIO changes only at MDC falling edges.
- R9: A control write that arrives while a frame is in progress starts nothing and leaves the control register unchanged.
- R10: Every frame begins with 32 ones followed by start bits 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| mdc_half | input | HALF_W | MDC half period in system cycles |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest case to reach is a control write that lands in the middle of a running frame. The bench issues a second, different control write after a fixed number of MDC rising edges. It then checks three things: the control readback still holds the first value, exactly 64 rising edges occur in total, and MDC stays low afterwards. Returned read data is driven by a responder that changes `mdio_i` only after MDC falling edges. This places each bit squarely under the rising edge it must be caught on. The sweep varies the PHY and register addresses, direction, data and half period, including the half period of zero.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_LEN = 64;
    localparam int PRE_LEN   = 32;
    localparam int TA_POS    = 46;
    localparam int DATA_POS  = 48;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [1:0] {
        REG_DATA  = 2'd0,
        REG_CTRL  = 2'd1,
        REG_READY = 2'd2,
        REG_NONE  = 2'd3
    } host_reg_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise,
    output logic              fall
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              mdc;
    } clk_state_t;

    clk_state_t q, d;
    logic [HALF_W-1:0] lim;

    always_comb begin
        lim  = (half == '0) ? '0 : half - 1'b1;
        d    = q;
        rise = 1'b0;
        fall = 1'b0;
        if (!en) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (q.cnt == lim) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
            rise  = ~q.mdc;
            fall  = q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;

    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);
    p_half_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$stable(q.mdc)) |-> ($past(q.cnt) == $past(lim)));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_write,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic                 busy;
        logic                 wr;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] sh;
        logic [15:0]          rd;
    } seq_state_t;

    seq_state_t q, d;
    logic [FRAME_LEN-1:0] frame;

    always_comb begin
        frame = {{PRE_LEN{1'b1}}, 2'b01, (is_write ? OP_WR : OP_RD), phy, regad,
                 (is_write ? 2'b10 : 2'b11), (is_write ? wdata : 16'hFFFF)};
        d    = q;
        done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.wr   = is_write;
                d.idx  = '0;
                d.sh   = frame;
            end
        end else begin
            if (rise && !q.wr && (q.idx >= IDX_W'(DATA_POS)))
                d.rd = {q.rd[14:0], mdio_i};
            if (fall) begin
                d.sh  = {q.sh[FRAME_LEN-2:0], 1'b1};
                d.idx = q.idx + 1'b1;
                if (q.idx == LAST) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign rdata   = q.rd;
    assign mdio_o  = q.busy ? q.sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = q.busy && (q.wr || (q.idx < IDX_W'(TA_POS)));

    p_preamble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && (q.idx < IDX_W'(PRE_LEN))) |-> (mdio_o && mdio_oe));
    p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> ($past(q.idx) == LAST));
    p_stable_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.busy) && q.busy && !$past(fall)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_bridge.sv
module mdio_bridge
    import mdio_pkg::*;
#(
    parameter int          HALF_W   = 8,
    parameter int          WE_BIT   = 15,
    parameter logic [9:0]  INIT_IDX = 10'h3B4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [HALF_W-1:0] mdc_half,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    typedef struct packed {
        logic [31:0] data;
        logic [31:0] ctrl;
    } regs_t;

    regs_t q, d;
    logic        busy, done, start, wr_ctrl, rise, fall;
    logic [15:0] rd_val;

    always_comb begin
        wr_ctrl = host_we && (host_addr == REG_CTRL);
        start   = wr_ctrl && !busy && (host_wdata[9:0] == INIT_IDX);
        d       = q;
        if (host_we && (host_addr == REG_DATA))
            d.data = host_wdata;
        if (wr_ctrl && !busy)
            d.ctrl = host_wdata;
        if (done && !q.ctrl[WE_BIT])
            d.data[15:0] = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (host_addr)
            REG_DATA:  host_rdata = q.data;
            REG_CTRL:  host_rdata = q.ctrl;
            REG_READY: host_rdata = {15'd0, ~busy, 16'd0};
            default:   host_rdata = '0;
        endcase
    end

    mdio_clkgen #(.HALF_W(HALF_W)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .half (mdc_half),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_write(host_wdata[WE_BIT]),
        .phy     (q.data[9:5]),
        .regad   (q.data[4:0]),
        .wdata   (q.data[31:16]),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .done    (done),
        .rdata   (rd_val),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && busy) |=> $stable(q.ctrl));
    p_ready_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_addr == REG_READY) |-> !host_rdata[16]);
    p_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_ctrl && host_wdata[9:0] == INIT_IDX)) |=> !busy);
endmodule

// File: tb/tb_mdio_bridge.sv
module tb_mdio_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  mdc_half = 8'd2;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] cap;
    logic [63:0] cap_oe;
    int          rise_cnt = 0;
    logic [15:0] resp = '0;
    int          hi_run = 0;
    int          bad_runs = 0;
    int          exp_half = 2;

    always #5 clk = ~clk;

    mdio_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc_half(mdc_half),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY responder and capture
    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap[63 - rise_cnt]    = mdio_o;
            cap_oe[63 - rise_cnt] = mdio_oe;
        end
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = resp[63 - rise_cnt];
        else                                  mdio_i = 1'b1;
    end

    always @(negedge clk) begin
        cycles = cycles + 1;
        if (mdc) hi_run = hi_run + 1;
        else if (hi_run != 0) begin
            if (hi_run != exp_half) bad_runs = bad_runs + 1;
            hi_run = 0;
        end
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] r;
        for (int i = 0; i < 5000; i++) begin
            hread(2'd2, r);
            if (r[16]) break;
        end
    endtask

    initial begin
        logic [31:0] r;
        logic [63:0] exp_mask;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        hread(2'd0, r); check("R1 data", 64'(r), 64'h0);
        hread(2'd1, r); check("R1 ctrl", 64'(r), 64'h0);
        hread(2'd2, r); check("R1 ready", 64'(r), 64'h0001_0000);
        check("R1 mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);

        // R5 wrong index starts nothing
        rise_cnt = 0;
        hwrite(2'd1, 32'h0000_0001);
        repeat (40) @(negedge clk);
        hread(2'd2, r); check("R5 ready", 64'(r), 64'h0001_0000);
        check("R5 no mdc", 64'(rise_cnt), 64'd0);
        hread(2'd1, r); check("R5 ctrl stored", 64'(r), 64'h1);

        // sweep
        for (int t = 0; t < 24; t++) begin
            logic [4:0]  phy;
            logic [4:0]  rg;
            logic        wr;
            logic [15:0] wd;
            logic [15:0] up;
            logic [7:0]  h;
            phy = 5'((t * 7 + 3) % 32);
            rg  = 5'((t * 11 + 5) % 32);
            if (t == 1) begin phy = 5'd31; rg = 5'd31; end
            if (t == 2) begin phy = 5'd0;  rg = 5'd0;  end
            wr  = t[0];
            wd  = 16'((t * 16'h1357) ^ 16'hA0C3);
            up  = 16'(16'h5A00 + t);
            h   = 8'(t % 4);
            mdc_half = h;
            exp_half = (h == 0) ? 1 : int'(h);
            resp = ~wd;
            rise_cnt = 0;
            bad_runs = 0;
            hwrite(2'd0, {(wr ? wd : up), 6'd0, phy, rg});
            hwrite(2'd1, {16'd0, wr, 5'd0, 10'h3B4});
            hread(2'd2, r); check("R6 busy", 64'(r), 64'h0);
            wait_done();
            hread(2'd2, r); check("R6 done", 64'(r), 64'h0001_0000);
            check("R10 preamble+start", {30'd0, cap[63:30]}, {30'd0, 32'hFFFF_FFFF, 2'b01});
            check(wr ? "R4 opcode" : "R3 opcode", 64'(cap[29:28]), wr ? 64'd1 : 64'd2);
            check("R2 addresses", 64'(cap[27:18]), 64'({phy, rg}));
            exp_mask = wr ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000;
            check("R7 oe window", cap_oe, exp_mask);
            hread(2'd0, r);
            if (wr) begin
                check("R4 ta+data", 64'(cap[17:0]), 64'({2'b10, wd}));
                check("R4 word kept", 64'(r), 64'({wd, 6'd0, phy, rg}));
            end else begin
                check("R7 read data", 64'(r), 64'({up, resp}));
            end
            check("R8 half period", 64'(bad_runs), 64'd0);
            check("R8 edge count", 64'(rise_cnt), 64'd64);
        end

        // R9 control write during a frame
        mdc_half = 8'd2; exp_half = 2;
        rise_cnt = 0;
        resp = 16'hC3A5;
        hwrite(2'd0, 32'h0000_00AF);
        hwrite(2'd1, 32'h0000_03B4);
        wait (rise_cnt == 10);
        hwrite(2'd1, 32'h0000_83B4);
        hread(2'd1, r); check("R9 ctrl unchanged", 64'(r), 64'h3B4);
        wait_done();
        repeat (60) @(negedge clk);
        check("R9 single frame", 64'(rise_cnt), 64'd64);
        check("R8 idle low", 64'(mdc), 64'd0);
        hread(2'd0, r); check("R9 read result", 64'(r), 64'h0000_C3A5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule